// File: doc/BRIEF.md
# Instruction Decoder and Sequencer

This block is the control unit of a small 16-bit processor. It walks every instruction through three phases: a fetch phase that waits for memory to flag a valid word and then captures the 9-bit instruction together with the accompanying data word, a decode phase that turns the 5-bit opcode into a set of operation strobes held in a register, and an execute phase in which exactly one of those strobes (or none, for an unused opcode) is driven to the arithmetic unit, the register array or the I/O ports.

The low four bits of the captured instruction are handed out unchanged. Depending on the operation they act as a port number, a register index, or a shift and rotate count. A program counter selects the next instruction. At the end of execute it either steps by one or, when the branch condition input is high, takes the low bits of the data word captured at fetch. The new value is copied into an address register that drives the memory address. The ready output marks the execute cycle, which is also the cycle in which the branch condition is sampled.

Top module: `ictl_top`

## Requirements
- R1: While reset is high and in the first cycle after it falls, ready is 0, every strobe is 0 and the memory address is 0.
- R2: In the fetch phase, while data_valid is 0, the block stays in fetch: ready stays 0 and the memory address does not change.
- R3: When data_valid is 1 in a fetch cycle, the instruction is captured, the next cycle is decode (ready 0) and the cycle after that is execute (ready 1 for exactly one cycle), after which the block returns to fetch.
- R4: The opcode is instruction bits 8..4. An opcode k in 1..15 raises alu_stb bit k-1 during execute, and no other strobe.
- R5: Opcode 16 raises port_wr_stb, 17 raises port_rd_stb, 18 raises rf_wr_stb and 19 raises rf_rd_stb during execute.
- R6: Opcode 0 and opcodes 20..31 raise no strobe.
- R7: At most one strobe is high in any cycle, and no strobe is high while ready is 0.
- R8: During execute, nibble equals bits 3..0 of the instruction captured at fetch, even if the instruction input has changed since.
- R9: At the end of an execute cycle with br_take 0, the memory address becomes the previous address plus one, wrapping from the top address to 0.
- R10: At the end of an execute cycle with br_take 1, the memory address becomes the low ADDR_W bits of the data word captured at fetch.
- R11: The memory address changes only at the end of an execute cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_in | input | 9 | Instruction word from memory |
| data_in | input | DATA_W | Data word from memory; low bits form the branch target |
| data_valid | input | 1 | Memory word valid, sampled in fetch |
| br_take | input | 1 | Branch condition, sampled in execute |
| mem_addr | output | ADDR_W | Address register driving the memory address |
| alu_stb | output | 15 | One-hot arithmetic/logic operation strobes |
| port_wr_stb | output | 1 | Port write strobe |
| port_rd_stb | output | 1 | Port read strobe |
| rf_wr_stb | output | 1 | Register-array write strobe |
| rf_rd_stb | output | 1 | Register-array read strobe |
| nibble | output | 4 | Operand field: port, register index or shift count |
| ready | output | 1 | High during the execute cycle |

## Verification
The program-counter step and the branch load both fall on the same closing edge of execute, and the counter wrap falls on it as well. The bench branches to the top address and then runs a plain instruction, so the next address must wrap to 0. It also mixes random branch conditions with random opcodes, predicting each following address from its own model. It changes the instruction and data inputs and toggles data_valid during decode and execute, and then judges that the nibble, the strobes and the branch target still come from the word captured at fetch.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

    localparam int OPC_W   = 5;
    localparam int NIB_W   = 4;
    localparam int INSTR_W = OPC_W + NIB_W;
    localparam int ALU_OPS = 15;

    localparam logic [OPC_W-1:0] OPC_PORT_WR = 5'd16;
    localparam logic [OPC_W-1:0] OPC_PORT_RD = 5'd17;
    localparam logic [OPC_W-1:0] OPC_RF_WR   = 5'd18;
    localparam logic [OPC_W-1:0] OPC_RF_RD   = 5'd19;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_e;

    typedef struct packed {
        logic [ALU_OPS-1:0] alu;
        logic               port_wr;
        logic               port_rd;
        logic               rf_wr;
        logic               rf_rd;
    } strobe_t;

    localparam int STB_W = $bits(strobe_t);

    function automatic strobe_t decode_opcode(input logic [OPC_W-1:0] opc);
        strobe_t s;
        s = '0;
        for (int k = 1; k <= ALU_OPS; k++) begin
            if (opc == k[OPC_W-1:0]) s.alu[k-1] = 1'b1;
        end
        unique case (opc)
            OPC_PORT_WR: s.port_wr = 1'b1;
            OPC_PORT_RD: s.port_rd = 1'b1;
            OPC_RF_WR:   s.rf_wr   = 1'b1;
            OPC_RF_RD:   s.rf_rd   = 1'b1;
            default:     ;
        endcase
        return s;
    endfunction

    function automatic phase_e next_phase(input phase_e ph, input logic valid);
        phase_e n;
        case (ph)
            PH_FETCH:  n = valid ? PH_DECODE : PH_FETCH;
            PH_DECODE: n = PH_EXEC;
            default:   n = PH_FETCH;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ictl_phase_seq.sv
module ictl_phase_seq
    import ictl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   data_valid,
    output phase_e phase_o,
    output logic   capture_o,
    output logic   decode_o,
    output logic   exec_o
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_FETCH;
        else     phase_q <= next_phase(phase_q, data_valid);
    end

    assign phase_o   = phase_q;
    assign capture_o = (phase_q == PH_FETCH) && data_valid;
    assign decode_o  = (phase_q == PH_DECODE);
    assign exec_o    = (phase_q == PH_EXEC);
endmodule

// File: rtl/ictl_instr_reg.sv
module ictl_instr_reg
    import ictl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [INSTR_W-1:0] instr_in,
    input  logic [DATA_W-1:0]  data_in,
    output logic [OPC_W-1:0]   opcode_o,
    output logic [NIB_W-1:0]   nibble_o,
    output logic [ADDR_W-1:0]  target_o
);
    logic [INSTR_W-1:0] ir_q;
    logic [ADDR_W-1:0]  tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q  <= '0;
            tgt_q <= '0;
        end else if (load) begin
            ir_q  <= instr_in;
            tgt_q <= data_in[ADDR_W-1:0];
        end
    end

    assign opcode_o = ir_q[INSTR_W-1:NIB_W];
    assign nibble_o = ir_q[NIB_W-1:0];
    assign target_o = tgt_q;
endmodule

// File: rtl/ictl_decoder.sv
module ictl_decoder
    import ictl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_en,
    input  logic             exec,
    input  logic [OPC_W-1:0] opcode,
    output strobe_t          strobe_o
);
    strobe_t dec_q;

    always_ff @(posedge clk) begin
        if (rst)         dec_q <= '0;
        else if (dec_en) dec_q <= decode_opcode(opcode);
    end

    assign strobe_o = exec ? dec_q : '0;
endmodule

// File: rtl/ictl_pc_unit.sv
module ictl_pc_unit #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              br_take,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] pc_next;

    assign pc_next = br_take ? target : pc_q + ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            addr_q <= '0;
        end else if (advance) begin
            pc_q   <= pc_next;
            addr_q <= pc_next;
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/ictl_top.sv
module ictl_top
    import ictl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [8:0]        instr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              data_valid,
    input  logic              br_take,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [14:0]       alu_stb,
    output logic              port_wr_stb,
    output logic              port_rd_stb,
    output logic              rf_wr_stb,
    output logic              rf_rd_stb,
    output logic [3:0]        nibble,
    output logic              ready
);
    phase_e           phase_q;
    logic             capture;
    logic             decode;
    logic             exec;
    logic [OPC_W-1:0] opcode;
    logic [ADDR_W-1:0] target;
    strobe_t          stb;

    ictl_phase_seq u_seq (
        .clk(clk), .rst(rst), .data_valid(data_valid),
        .phase_o(phase_q), .capture_o(capture), .decode_o(decode), .exec_o(exec)
    );

    ictl_instr_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ir (
        .clk(clk), .rst(rst), .load(capture),
        .instr_in(instr_in), .data_in(data_in),
        .opcode_o(opcode), .nibble_o(nibble), .target_o(target)
    );

    ictl_decoder u_dec (
        .clk(clk), .rst(rst), .dec_en(decode), .exec(exec),
        .opcode(opcode), .strobe_o(stb)
    );

    ictl_pc_unit #(.ADDR_W(ADDR_W)) u_pc (
        .clk(clk), .rst(rst), .advance(exec), .br_take(br_take),
        .target(target), .addr_o(mem_addr)
    );

    assign alu_stb     = stb.alu;
    assign port_wr_stb = stb.port_wr;
    assign port_rd_stb = stb.port_rd;
    assign rf_wr_stb   = stb.rf_wr;
    assign rf_rd_stb   = stb.rf_rd;
    assign ready       = exec;
endmodule

// File: rtl/ictl_checker.sv
module ictl_checker
    import ictl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              data_valid,
    input logic              br_take,
    input phase_e            phase_q,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [14:0]       alu_stb,
    input logic              port_wr_stb,
    input logic              port_rd_stb,
    input logic              rf_wr_stb,
    input logic              rf_rd_stb,
    input logic              ready
);
    logic [18:0] all_stb;
    assign all_stb = {alu_stb, port_wr_stb, port_rd_stb, rf_wr_stb, rf_rd_stb};

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!ready && mem_addr == '0 && all_stb == '0));

    assert_fetch_waits_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH && !data_valid) |=> (phase_q == PH_FETCH && !ready));

    assert_ready_single_R3: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_stb));

    assert_strobe_in_exec_R7: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (all_stb == '0));

    assert_step_R9: assert property (@(posedge clk) disable iff (rst)
        (ready && !br_take) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !ready |=> $stable(mem_addr));
endmodule

bind ictl_top ictl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .data_valid(data_valid), .br_take(br_take),
    .phase_q(phase_q), .mem_addr(mem_addr), .alu_stb(alu_stb),
    .port_wr_stb(port_wr_stb), .port_rd_stb(port_rd_stb),
    .rf_wr_stb(rf_wr_stb), .rf_rd_stb(rf_rd_stb), .ready(ready)
);

// File: tb/ictl_top_test.sv
module ictl_top_test;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [8:0]        instr_in = '0;
    logic [DATA_W-1:0] data_in = '0;
    logic              data_valid = 1'b0;
    logic              br_take = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [14:0]       alu_stb;
    logic              port_wr_stb, port_rd_stb, rf_wr_stb, rf_rd_stb;
    logic [3:0]        nibble;
    logic              ready;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [ADDR_W-1:0] exp_pc = '0;

    always #2 clk = ~clk;

    ictl_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .instr_in(instr_in), .data_in(data_in),
        .data_valid(data_valid), .br_take(br_take), .mem_addr(mem_addr),
        .alu_stb(alu_stb), .port_wr_stb(port_wr_stb), .port_rd_stb(port_rd_stb),
        .rf_wr_stb(rf_wr_stb), .rf_rd_stb(rf_rd_stb), .nibble(nibble), .ready(ready)
    );

    function automatic logic [18:0] strobes_now();
        return {alu_stb, port_wr_stb, port_rd_stb, rf_wr_stb, rf_rd_stb};
    endfunction

    // Layout {alu[14:0], port_wr, port_rd, rf_wr, rf_rd}
    function automatic logic [18:0] expect_strobes(input int opc);
        logic [18:0] v;
        v = '0;
        if (opc >= 1 && opc <= 15) v[opc + 3] = 1'b1;
        else if (opc == 16) v[3] = 1'b1;
        else if (opc == 17) v[2] = 1'b1;
        else if (opc == 18) v[1] = 1'b1;
        else if (opc == 19) v[0] = 1'b1;
        return v;
    endfunction

    function automatic string opc_req(input int opc);
        if (opc >= 1 && opc <= 15) return "R4";
        if (opc >= 16 && opc <= 19) return "R5";
        return "R6";
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_instr(input int opc, input logic [3:0] nib,
                             input logic [DATA_W-1:0] data, input bit br, input int wait_n);
        logic [18:0] es;
        for (int i = 0; i < wait_n; i++) begin
            data_valid = 1'b0;
            instr_in   = 9'($urandom);
            @(negedge clk);
            check(ready == 1'b0 && mem_addr == exp_pc, "R2", {mem_addr, 7'd0, ready}, {exp_pc, 8'd0});
        end
        instr_in   = {opc[4:0], nib};
        data_in    = data;
        data_valid = 1'b1;
        @(negedge clk);
        check(ready == 1'b0, "R3 decode", 32'(ready), 32'd0);
        // disturb inputs outside fetch
        instr_in   = 9'($urandom);
        data_in    = DATA_W'($urandom);
        data_valid = 1'($urandom);
        @(negedge clk);
        check(ready == 1'b1, "R3 execute", 32'(ready), 32'd1);
        es = expect_strobes(opc);
        check(strobes_now() == es, opc_req(opc), 32'(strobes_now()), 32'(es));
        check(nibble == nib, "R8", 32'(nibble), 32'(nib));
        check(mem_addr == exp_pc, "R11", 32'(mem_addr), 32'(exp_pc));
        br_take    = br;
        data_valid = 1'b0;
        @(negedge clk);
        br_take = 1'b0;
        exp_pc  = br ? data[ADDR_W-1:0] : exp_pc + ADDR_W'(1);
        check(mem_addr == exp_pc, br ? "R10" : "R9", 32'(mem_addr), 32'(exp_pc));
        check(ready == 1'b0 && strobes_now() == '0, "R7", 32'(strobes_now()), 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(ready == 1'b0 && mem_addr == '0 && strobes_now() == '0, "R1 in reset",
              {mem_addr, 7'd0, ready}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b0 && mem_addr == '0 && strobes_now() == '0, "R1 after reset",
              {mem_addr, 7'd0, ready}, 32'd0);

        // every opcode once, with a wait on some
        for (int op = 0; op < 32; op++) begin
            run_instr(op, 4'(op * 7), 16'h1234, 1'b0, op % 3);
        end
        // branch to top address then wrap by stepping
        run_instr(1, 4'hA, 16'h00FF, 1'b1, 2);
        run_instr(5, 4'h3, 16'h0000, 1'b0, 0);
        check(mem_addr == '0, "R9 wrap", 32'(mem_addr), 32'd0);
        // branch with high data bits set
        run_instr(16, 4'hF, 16'hAB42, 1'b1, 4);
        run_instr(0, 4'h0, 16'hFFFF, 1'b0, 1);

        for (int n = 0; n < 80; n++) begin
            run_instr(int'($urandom % 32), 4'($urandom), DATA_W'($urandom),
                      1'($urandom), int'($urandom % 4));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule